// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the cycle-level front end of a small 8-bit processor. It owns the opcode fetch step and the single entry sequence shared by reset, the non-maskable interrupt, the maskable interrupt and the software break instruction. At every instruction boundary it places the program counter on the address bus and raises a sync strobe. If no request is pending, the fetched byte goes into the instruction register and the program counter advances. If a request is pending, the fetch still takes place, but the byte is thrown away. The break opcode is loaded in its place and the program counter is held, so the pre-empted instruction is fetched again after the handler returns.

The entry sequence reads one more byte: the signature byte for a software break, or a repeat read of the same address for a hardware request. It then pushes the return address and the status byte to the stack page and reads a two-byte vector. The vector is chosen from request bits that are captured at the fetch. Reset beats NMI, and NMI beats IRQ and break. A minimal return sequence pops the status byte and the program counter. Every opcode other than break and return is treated as a one-cycle instruction, because general execution is handled elsewhere.

The memory bus is synchronous. Read data is valid in the same cycle as the address that selects it, and a write takes effect at the clock edge that ends a cycle with the write strobe high.

Top module: `irq_entry_seq`

## Requirements
- R1: In a fetch cycle, sync is 1, the address equals the program counter, and the write strobe is 0. In the next cycle the opcode output holds the fetched byte. An opcode other than $00 and $40 lasts one cycle, and the next fetch is at the program counter plus one.
- R2: When a request is pending in a fetch cycle, the bus still shows the fetch (sync 1, address equal to the program counter). In the next cycle the opcode output is $00, whatever byte was read.
- R3: For a hardware entry, the cycle after the fetch reads the same address again with sync 0. The pushed return address is the address of the pre-empted opcode, and that opcode is fetched again after the return.
- R4: A fetched $00 with nothing pending is a software break. Its second cycle reads the opcode address plus one with sync 0, and the pushed return address is the opcode address plus two.
- R5: The pushed status byte equals the status output with bit 5 forced to 1. Bit 4 is 1 for a software break and 0 for a hardware entry.
- R6: A non-reset entry makes three consecutive write cycles to $0100 plus the stack pointer: return address high byte, then low byte, then status. The stack pointer drops by one after each write.
- R7: Status bit 2 (the mask bit) is set after the push and is already 1 at the handler's first fetch. While bit 2 is 1, a low irq_n has no effect. While bit 2 is 0, a low irq_n at a fetch starts an entry.
- R8: The vector low byte is read from $FFFA for NMI, $FFFC for reset and $FFFE for IRQ or break. The high byte is read from the next address in the next cycle, and the handler's first fetch is at the assembled address. When reset and NMI are pending together, reset is served first, and the NMI is taken at the reset handler's first fetch.
- R9: A reset entry asserts no write strobe. It sets the stack pointer to SP_INIT ($FF) and sets status bit 2. After the rst input is released, the first cycle is a fetch at RESET_PC (status $24), and a reset entry follows it.
- R10: A falling edge on nmi_n is latched and taken at the next fetch, whatever the state of status bit 2. Holding nmi_n low gives exactly one entry, and a further entry needs a new falling edge.
- R11: The vector choice is fixed at the fetch that starts the entry. A falling edge on nmi_n during the push cycles does not change the vector being read, and the NMI is taken at the following fetch.
- R12: A fetched $40 with nothing pending reads $0100 plus SP+1, SP+2 and SP+3 in order, giving status, PC low and PC high. The stack pointer rises by 3. The status becomes the popped byte with bit 4 cleared and bit 5 set, and the next fetch is at the popped address.
- R13: A high rst_req at a fetch starts a reset entry, even when no reset of the block has occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset; leaves a reset entry pending |
| rst_req | input | 1 | Level request for a reset entry, sampled at fetch cycles |
| nmi_n | input | 1 | Non-maskable request, active on its falling edge |
| irq_n | input | 1 | Maskable request, active-low level |
| mem_addr | output | 16 | Bus address |
| mem_rdata | input | 8 | Read data for the current address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| sync | output | 1 | High during opcode fetch cycles |
| opcode | output | 8 | Instruction register |
| status | output | 8 | Status byte; bit 2 masks irq_n |

## Verification
The assertions assume that read data answers the current address in the same cycle, and that no code sits on the vector addresses or on the stack page. They also assume that rst_req and nmi_n change only between clock edges and stay at each level for at least one full cycle. The stimulus drives every input at the falling clock edge and holds it for whole cycles. The memory model keeps programs in pages $00, $02 and $03, with vectors only at $FFFA-$FFFF. The program visits the mask bit in both states before it relies on it, and it lifts rst_req again right after the fetch that samples it.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;

  typedef enum logic [3:0] {
    S_FETCH,
    S_SIG,
    S_PSH_H,
    S_PSH_L,
    S_PSH_P,
    S_VEC_L,
    S_VEC_H,
    S_POP_P,
    S_POP_L,
    S_POP_H
  } seq_state_t;

  localparam int FLAG_I = 2;
  localparam int FLAG_B = 4;
  localparam int FLAG_U = 5;

endpackage

// File: rtl/irqseq_nmi_latch.sv
module irqseq_nmi_latch (
  input  logic clk,
  input  logic rst,
  input  logic nmi_n,
  input  logic ack,
  output logic pend
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      pend   <= 1'b0;
    end else begin
      prev_q <= nmi_n;
      if (prev_q && !nmi_n)
        pend <= 1'b1;
      else if (ack)
        pend <= 1'b0;
    end
  end

endmodule

// File: rtl/irqseq_vec_sel.sv
module irqseq_vec_sel #(
  parameter int AW = 16
) (
  input  logic          vrst,
  input  logic          vnmi,
  input  logic          hi_byte,
  output logic [AW-1:0] addr
);

  localparam int TOPW = AW - 3;

  // reset clears bit 1; NMI clears bit 2 unless reset is also latched
  always_comb begin
    addr = {{TOPW{1'b1}}, ~(vnmi & ~vrst), ~vrst, hi_byte};
  end

endmodule

// File: rtl/irqseq_stack.sv
module irqseq_stack #(
  parameter int          SPW     = 8,
  parameter logic [SPW-1:0] SP_INIT = '1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           dec,
  input  logic           inc,
  input  logic           force_init,
  output logic [SPW-1:0] sp,
  output logic [SPW-1:0] sp_up
);

  assign sp_up = sp + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)             sp <= SP_INIT;
    else if (force_init) sp <= SP_INIT;
    else if (dec)        sp <= sp - 1'b1;
    else if (inc)        sp <= sp_up;
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irqseq_pkg::*;
#(
  parameter int              DW         = 8,
  parameter logic [2*DW-1:0] RESET_PC   = '0,
  parameter logic [DW-1:0]   SP_INIT    = '1,
  parameter logic [DW-1:0]   STACK_PAGE = 8'h01,
  parameter logic [DW-1:0]   OP_BRK     = 8'h00,
  parameter logic [DW-1:0]   OP_RTI     = 8'h40,
  parameter logic [DW-1:0]   P_RESET    = 8'h24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_req,
  input  logic              nmi_n,
  input  logic              irq_n,
  output logic [2*DW-1:0]   mem_addr,
  input  logic [DW-1:0]     mem_rdata,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_we,
  output logic              sync,
  output logic [DW-1:0]     opcode,
  output logic [DW-1:0]     status
);

  localparam int          AW     = 2 * DW;
  localparam logic [DW-1:0] B_MASK = DW'(1) << FLAG_B;
  localparam logic [DW-1:0] U_MASK = DW'(1) << FLAG_U;

  seq_state_t    state;
  logic [AW-1:0] pc;
  logic [DW-1:0] ir, pflags;
  logic          sw_q, vrst_q, vnmi_q, rst_pend;
  logic          nmi_pend, nmi_ack;
  logic          rst_live, irq_live, take;
  logic          in_push, in_pop;
  logic [DW-1:0] sp, sp_up;
  logic [AW-1:0] vec_addr;

  always_comb begin
    rst_live = rst_pend | rst_req;
    irq_live = !irq_n && !pflags[FLAG_I];
    take     = rst_live | nmi_pend | irq_live;
    nmi_ack  = (state == S_FETCH) && !rst_live && nmi_pend;
    in_push  = (state == S_PSH_H) || (state == S_PSH_L) || (state == S_PSH_P);
    in_pop   = (state == S_POP_P) || (state == S_POP_L) || (state == S_POP_H);
  end

  irqseq_nmi_latch u_nmi (
    .clk  (clk),
    .rst  (rst),
    .nmi_n(nmi_n),
    .ack  (nmi_ack),
    .pend (nmi_pend)
  );

  irqseq_stack #(.SPW(DW), .SP_INIT(SP_INIT)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .dec       (in_push && !vrst_q),
    .inc       (in_pop),
    .force_init(state == S_PSH_P && vrst_q),
    .sp        (sp),
    .sp_up     (sp_up)
  );

  irqseq_vec_sel #(.AW(AW)) u_vec (
    .vrst   (vrst_q),
    .vnmi   (vnmi_q),
    .hi_byte(state == S_VEC_H),
    .addr   (vec_addr)
  );

  // bus drive from registered state
  always_comb begin
    mem_addr  = pc;
    mem_wdata = '0;
    case (state)
      S_PSH_H: begin mem_addr = {STACK_PAGE, sp}; mem_wdata = pc[AW-1:DW]; end
      S_PSH_L: begin mem_addr = {STACK_PAGE, sp}; mem_wdata = pc[DW-1:0]; end
      S_PSH_P: begin
        mem_addr  = {STACK_PAGE, sp};
        mem_wdata = pflags | U_MASK | (sw_q ? B_MASK : '0);
      end
      S_VEC_L, S_VEC_H:          mem_addr = vec_addr;
      S_POP_P, S_POP_L, S_POP_H: mem_addr = {STACK_PAGE, sp_up};
      default:                   mem_addr = pc;
    endcase
  end

  assign mem_we = in_push && !vrst_q;
  assign sync   = (state == S_FETCH);
  assign opcode = ir;
  assign status = pflags;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_FETCH;
      pc       <= RESET_PC;
      ir       <= '0;
      pflags   <= P_RESET;
      sw_q     <= 1'b0;
      vrst_q   <= 1'b0;
      vnmi_q   <= 1'b0;
      rst_pend <= 1'b1;
    end else begin
      case (state)
        S_FETCH: begin
          if (take) begin
            ir       <= OP_BRK;
            sw_q     <= 1'b0;
            vrst_q   <= rst_live;
            vnmi_q   <= nmi_pend;
            rst_pend <= 1'b0;
            state    <= S_SIG;
          end else begin
            ir     <= mem_rdata;
            pc     <= pc + 1'b1;
            sw_q   <= 1'b1;
            vrst_q <= 1'b0;
            vnmi_q <= 1'b0;
            if (mem_rdata == OP_BRK)      state <= S_SIG;
            else if (mem_rdata == OP_RTI) state <= S_POP_P;
            else                          state <= S_FETCH;
          end
        end
        S_SIG: begin
          if (sw_q) pc <= pc + 1'b1;
          state <= S_PSH_H;
        end
        S_PSH_H: state <= S_PSH_L;
        S_PSH_L: state <= S_PSH_P;
        S_PSH_P: begin
          pflags[FLAG_I] <= 1'b1;
          state          <= S_VEC_L;
        end
        S_VEC_L: begin
          pc[DW-1:0] <= mem_rdata;
          state      <= S_VEC_H;
        end
        S_VEC_H: begin
          pc[AW-1:DW] <= mem_rdata;
          state       <= S_FETCH;
        end
        S_POP_P: begin
          pflags <= (mem_rdata & ~B_MASK) | U_MASK;
          state  <= S_POP_L;
        end
        S_POP_L: begin
          pc[DW-1:0] <= mem_rdata;
          state      <= S_POP_H;
        end
        S_POP_H: begin
          pc[AW-1:DW] <= mem_rdata;
          state       <= S_FETCH;
        end
        default: state <= S_FETCH;
      endcase
    end
  end

endmodule

// File: rtl/irqseq_checker.sv
module irqseq_checker
  import irqseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          sync,
  input logic [DW-1:0] opcode,
  input logic [DW-1:0] status,
  input seq_state_t    st,
  input logic          sw_q,
  input logic          vrst_q,
  input logic          vnmi_q
);

  assert_fetch_no_write_R1: assert property (@(posedge clk) disable iff (rst)
    sync |-> !mem_we);

  assert_break_loaded_R2: assert property (@(posedge clk) disable iff (rst)
    (st == S_SIG) |-> (opcode == '0));

  assert_hw_holds_addr_R3: assert property (@(posedge clk) disable iff (rst)
    (st == S_SIG && !sw_q) |-> (mem_addr == $past(mem_addr)));

  assert_write_in_stack_page_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[AW-1:DW] == 8'h01));

  assert_mask_before_vector_R7: assert property (@(posedge clk) disable iff (rst)
    (st == S_VEC_L) |-> status[FLAG_I]);

  assert_vector_pair_R8: assert property (@(posedge clk) disable iff (rst)
    (st == S_VEC_L) |=> (st == S_VEC_H && mem_addr == $past(mem_addr) + 1'b1));

  assert_reset_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    vrst_q |-> !mem_we);

  assert_vector_bits_held_R11: assert property (@(posedge clk) disable iff (rst)
    (st != S_FETCH) |=> ($stable(vrst_q) && $stable(vnmi_q)));

  assert_pop_sequence_R12: assert property (@(posedge clk) disable iff (rst)
    (st == S_POP_P) |=> (st == S_POP_L && mem_addr == $past(mem_addr) + 1'b1));

endmodule

bind irq_entry_seq irqseq_checker #(.AW(2*DW), .DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mem_addr(mem_addr),
  .mem_we  (mem_we),
  .sync    (sync),
  .opcode  (opcode),
  .status  (status),
  .st      (state),
  .sw_q    (sw_q),
  .vrst_q  (vrst_q),
  .vnmi_q  (vnmi_q)
);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;
  localparam int K_IRQ = 0;
  localparam int K_NMI = 1;
  localparam int K_RST = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rst_req = 1'b0;
  logic        nmi_n = 1'b1;
  logic        irq_n = 1'b1;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        sync;
  logic [7:0]  opcode;
  logic [7:0]  status;

  logic [7:0] code_m [0:1023];
  logic [7:0] stk_m  [0:255];

  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;
  logic [7:0] m_sp;
  logic [7:0] m_p;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst(rst), .rst_req(rst_req), .nmi_n(nmi_n), .irq_n(irq_n),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .sync(sync), .opcode(opcode), .status(status)
  );

  // memory model: stack page, vectors, code mirrored on addr[9:0]
  always_comb begin
    if (mem_addr[15:8] == 8'h01)
      mem_rdata = stk_m[mem_addr[7:0]];
    else if (mem_addr >= 16'hFFFA) begin
      case (mem_addr[2:0])
        3'd2:    mem_rdata = 8'h00;
        3'd3:    mem_rdata = 8'h03;
        3'd4:    mem_rdata = 8'h00;
        3'd5:    mem_rdata = 8'h02;
        3'd6:    mem_rdata = 8'h80;
        default: mem_rdata = 8'h00;
      endcase
    end else
      mem_rdata = code_m[mem_addr[9:0]];
  end

  always @(posedge clk)
    if (mem_we && mem_addr[15:8] == 8'h01)
      stk_m[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  // plain one-cycle fetch
  task automatic fetch(input logic [15:0] a);
    chk("R1", "sync", {31'd0, sync}, 32'd1);
    chk("R1", "fetch addr", {16'd0, mem_addr}, {16'd0, a});
    chk("R1", "no write", {31'd0, mem_we}, 32'd0);
    nxt();
    chk("R1", "opcode", {24'd0, opcode}, {24'd0, code_m[a[9:0]]});
  endtask

  task automatic entry(input logic [15:0] a, input bit sw, input int kind,
                       input int nmi_cyc);
    logic [15:0] ret, vec, tgt;
    logic [7:0]  pv, wexp;
    ret = a + (sw ? 16'd2 : 16'd0);
    pv  = m_p | 8'h20 | (sw ? 8'h10 : 8'h00);
    vec = (kind == K_NMI) ? 16'hFFFA : (kind == K_RST) ? 16'hFFFC : 16'hFFFE;
    tgt = (kind == K_NMI) ? 16'h0300 : (kind == K_RST) ? 16'h0200 : 16'h0080;
    chk("R2", "entry fetch sync", {31'd0, sync}, 32'd1);
    chk("R2", "entry fetch addr", {16'd0, mem_addr}, {16'd0, a});
    nxt();
    if (kind == K_RST) rst_req = 1'b0;
    chk("R2", "break substituted", {24'd0, opcode}, 32'd0);
    chk(sw ? "R4" : "R3", "second read addr", {16'd0, mem_addr},
        {16'd0, a + (sw ? 16'd1 : 16'd0)});
    chk("R3", "second read sync", {31'd0, sync}, 32'd0);
    nxt();
    for (int k = 0; k < 3; k++) begin
      if (kind == K_RST) begin
        chk("R9", "reset no write", {31'd0, mem_we}, 32'd0);
      end else begin
        wexp = (k == 0) ? ret[15:8] : (k == 1) ? ret[7:0] : pv;
        chk("R6", "push strobe", {31'd0, mem_we}, 32'd1);
        chk("R6", "push addr", {16'd0, mem_addr}, {16'd0, 8'h01, m_sp - 8'(k)});
        chk((k == 2) ? "R5" : "R4", "push data", {24'd0, mem_wdata}, {24'd0, wexp});
      end
      if (k == nmi_cyc) nmi_n = 1'b0;
      nxt();
    end
    m_sp = (kind == K_RST) ? 8'hFF : m_sp - 8'd3;
    chk((nmi_cyc >= 0) ? "R11" : "R8", "vector low", {16'd0, mem_addr}, {16'd0, vec});
    nxt();
    chk("R8", "vector high", {16'd0, mem_addr}, {16'd0, vec + 16'd1});
    nxt();
    chk("R8", "handler fetch", {16'd0, mem_addr}, {16'd0, tgt});
    chk("R7", "mask set", {31'd0, status[2]}, 32'd1);
    m_p = m_p | 8'h04;
  endtask

  task automatic rti(input logic [15:0] a, input logic [15:0] ret,
                     input logic [7:0] pexp);
    chk("R12", "rti fetch addr", {16'd0, mem_addr}, {16'd0, a});
    chk("R12", "rti fetch sync", {31'd0, sync}, 32'd1);
    nxt();
    chk("R12", "rti opcode", {24'd0, opcode}, 32'h40);
    for (int k = 1; k <= 3; k++) begin
      chk("R12", "pop addr", {16'd0, mem_addr}, {16'd0, 8'h01, m_sp + 8'(k)});
      chk("R12", "pop no write", {31'd0, mem_we}, 32'd0);
      nxt();
    end
    m_sp = m_sp + 8'd3;
    m_p  = pexp;
    chk("R12", "return fetch", {16'd0, mem_addr}, {16'd0, ret});
    chk("R12", "status restored", {24'd0, status}, {24'd0, pexp});
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) code_m[i] = 8'hEA;
    for (int i = 0; i < 256; i++) stk_m[i] = 8'h00;
    code_m[10'h203] = 8'h40;
    code_m[10'h212] = 8'h00;
    code_m[10'h213] = 8'h5A;
    code_m[10'h081] = 8'h40;
    code_m[10'h303] = 8'h40;
    stk_m[8'h00] = 8'h00;
    stk_m[8'h01] = 8'h10;
    stk_m[8'h02] = 8'h02;
    m_sp = 8'hFF;
    m_p  = 8'h24;

    repeat (3) nxt();
    rst = 1'b0;
    // R9: state right after block reset
    chk("R9", "reset sync", {31'd0, sync}, 32'd1);
    chk("R9", "reset addr", {16'd0, mem_addr}, 32'd0);
    chk("R9", "reset status", {24'd0, status}, 32'h24);
    entry(16'h0000, 1'b0, K_RST, -1);
    fetch(16'h0200);
    fetch(16'h0201);
    fetch(16'h0202);
    rti(16'h0203, 16'h0210, 8'h20);
    fetch(16'h0210);
    fetch(16'h0211);
    // R4/R5 software break; R11 NMI edge during the push
    entry(16'h0212, 1'b1, K_IRQ, 1);
    // R10 latched NMI taken at handler entry, mask bit set
    entry(16'h0080, 1'b0, K_NMI, -1);
    nmi_n = 1'b1;
    fetch(16'h0300);
    fetch(16'h0301);
    fetch(16'h0302);
    rti(16'h0303, 16'h0080, 8'h24);
    fetch(16'h0080);
    rti(16'h0081, 16'h0214, 8'h20);
    fetch(16'h0214);
    fetch(16'h0215);
    // R7 level IRQ with mask clear
    irq_n = 1'b0;
    entry(16'h0216, 1'b0, K_IRQ, -1);
    // R7 masked: handler runs while irq_n stays low
    fetch(16'h0080);
    irq_n = 1'b1;
    rti(16'h0081, 16'h0216, 8'h20);
    // R3 pre-empted opcode fetched again; NMI edge now
    nmi_n = 1'b0;
    fetch(16'h0216);
    entry(16'h0217, 1'b0, K_NMI, -1);
    // R10 held low: no second entry
    fetch(16'h0300);
    nmi_n = 1'b1;
    fetch(16'h0301);
    nmi_n = 1'b0;
    fetch(16'h0302);
    // R10 new edge taken with mask set, pre-empting the return opcode
    entry(16'h0303, 1'b0, K_NMI, -1);
    fetch(16'h0300);
    fetch(16'h0301);
    fetch(16'h0302);
    rti(16'h0303, 16'h0303, 8'h24);
    rti(16'h0303, 16'h0217, 8'h20);
    nmi_n = 1'b1;
    fetch(16'h0217);
    nmi_n = 1'b0;
    fetch(16'h0218);
    // R13 reset request, R8 reset wins over pending NMI
    rst_req = 1'b1;
    entry(16'h0219, 1'b0, K_RST, -1);
    chk("R8", "nmi kept pending", {31'd0, sync}, 32'd1);
    entry(16'h0200, 1'b0, K_NMI, -1);
    fetch(16'h0300);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 act=%0d exp=finished", WD_CYCLES);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule